// File: doc/BRIEF.md
# Table-Driven Finite State Machine

This block is a finite state machine whose transition function and output decoding are held entirely in a synchronous lookup memory. There is no hand-written next-state gate logic. The current state code and the sampled input bits together form the read address. Each memory word carries the code of the following state together with the output bits for that state. The word read out on a clock edge is the machine's register: its low field is the present state and is fed back into the address.

The table is filled during elaboration. A generate loop visits every address, splits it into its state and input fields, and asks a constant function in the package for the following state and the outputs that go with it. To change the behaviour, only that function changes.

The demonstration table uses states 0 to 4:

| State | Outputs | Next state |
|-------|---------|------------|
| 0 | none | 1 when input 0 is high, else 0 |
| 1 | output 0 | 2 when input 1 is high, else 3 |
| 2 | output 1 | 3 always |
| 3 | outputs 0 and 1 | 0 when input 0 is high, else 4 |
| 4 | none | 0 when inputs 0 and 1 are both high, else 4 |

Every other code is unused.

Top module: `table_fsm`

## Requirements
- R1: The read address places the state code in bits [STATE_W-1:0]; input bit k sits at address bit STATE_W+k.
- R2: A table word holds the following state code in bits [STATE_W-1:0]; output bit k sits at word bit STATE_W+k.
- R3: A synchronous active-high reset loads state 0 and clears all outputs on the next edge, overriding whatever the table would have supplied.
- R4: On each rising edge without reset, the state becomes the table's next state for the previous state and the inputs sampled at that edge, with exactly one cycle of latency and no extra register stage.
- R5: The outputs always equal the outputs stored for the state just entered (Moore timing).
- R6: Any output that a state's entry does not drive reads 0; states 0 and 4 drive no output.
- R7: Every unused state code (5 and above) leads to state 0 with all outputs 0 for every input combination.
- R8: State 0 advances to 1 only while input 0 is high, and otherwise stays at 0.
- R9: State 1 branches to 2 when input 1 is high and to 3 otherwise.
- R10: State 2 ignores its inputs and always advances to 3.
- R11: State 3 returns to 0 when input 0 is high and moves to 4 otherwise; state 4 holds until inputs 0 and 1 are both high, then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bits | input | IN_W | Condition inputs sampled every edge |
| out_bits | output | OUT_W | Moore outputs of the current state |
| state | output | STATE_W | Current state code |

## Verification
The bench reads every address of a separately instantiated table through its own ports. Against an arithmetic reference, this exposes a swapped state/input split in the address or a misplaced output field in the word, either of which would corrupt whole address ranges. The same sweep covers each unused code under all input values, so a table that left such an entry at zero outputs but a nonzero next code would be caught. On the full machine, a pseudo-random input stream steers through every branch. A design with an added register stage would lag the reference by one cycle. One that showed the previous state's outputs would disagree on every branch. A reset asserted while the table is about to branch checks that reset wins over the table read.

// File: rtl/tfsm_pkg.sv
package tfsm_pkg;

   // Demonstration transition function: next state from state and input vector.
   function automatic int tfsm_next(input int st, input int ins);
      int i0;
      int i1;
      i0 = ins & 1;
      i1 = (ins >> 1) & 1;
      case (st)
         0:       return (i0 != 0) ? 1 : 0;
         1:       return (i1 != 0) ? 2 : 3;
         2:       return 3;
         3:       return (i0 != 0) ? 0 : 4;
         4:       return ((i0 != 0) && (i1 != 0)) ? 0 : 4;
         default: return 0;
      endcase
   endfunction

   // Moore outputs belonging to a state; undriven bits stay 0.
   function automatic int tfsm_outs(input int st);
      case (st)
         1:       return 1;
         2:       return 2;
         3:       return 3;
         default: return 0;
      endcase
   endfunction

   function automatic bit tfsm_used(input int st);
      return (st >= 0) && (st <= 4);
   endfunction

endpackage

// File: rtl/tfsm_addr.sv
module tfsm_addr #(
   parameter int STATE_W = 5,
   parameter int IN_W    = 2,
   localparam int AW     = STATE_W + IN_W
) (
   input  logic [STATE_W-1:0] state,
   input  logic [IN_W-1:0]    in_bits,
   output logic [AW-1:0]      addr
);
   // State in the low field, inputs directly above it.
   for (genvar k = 0; k < AW; k++) begin : g_bit
      if (k < STATE_W) begin : g_st
         assign addr[k] = state[k];
      end else begin : g_in
         assign addr[k] = in_bits[k-STATE_W];
      end
   end
endmodule

// File: rtl/tfsm_rom.sv
module tfsm_rom #(
   parameter int STATE_W = 5,
   parameter int IN_W    = 2,
   parameter int OUT_W   = 2,
   localparam int AW     = STATE_W + IN_W,
   localparam int WORD_W = STATE_W + OUT_W,
   localparam int DEPTH  = 1 << AW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [AW-1:0]     addr,
   output logic [WORD_W-1:0] q
);
   localparam int ST_MASK  = (1 << STATE_W) - 1;
   localparam int OUT_MASK = (1 << OUT_W) - 1;

   logic [WORD_W-1:0] tbl [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_word
      localparam int ST_C = a & ST_MASK;
      localparam int IN_C = a >> STATE_W;
      localparam int NX_C = tfsm_pkg::tfsm_next(ST_C, IN_C) & ST_MASK;
      localparam int OU_C = tfsm_pkg::tfsm_outs(NX_C) & OUT_MASK;
      assign tbl[a] = WORD_W'((OU_C << STATE_W) | NX_C);
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= tbl[addr];
   end
endmodule

// File: rtl/tfsm_unpack.sv
module tfsm_unpack #(
   parameter int STATE_W = 5,
   parameter int OUT_W   = 2,
   localparam int WORD_W = STATE_W + OUT_W
) (
   input  logic [WORD_W-1:0]  word,
   output logic [STATE_W-1:0] state,
   output logic [OUT_W-1:0]   out_bits
);
   assign state    = word[STATE_W-1:0];
   assign out_bits = word[WORD_W-1:STATE_W];
endmodule

// File: rtl/table_fsm.sv
module table_fsm #(
   parameter int STATE_W = 5,
   parameter int IN_W    = 2,
   parameter int OUT_W   = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [IN_W-1:0]    in_bits,
   output logic [OUT_W-1:0]   out_bits,
   output logic [STATE_W-1:0] state
);
   localparam int AW     = STATE_W + IN_W;
   localparam int WORD_W = STATE_W + OUT_W;

   if (STATE_W < 3 || STATE_W > 8) begin : g_bad_sw
      $error("table_fsm: STATE_W must lie in 3..8");
   end
   if (IN_W < 2 || OUT_W < 2) begin : g_bad_io
      $error("table_fsm: demonstration table needs two inputs and two outputs");
   end
   if (AW > 12) begin : g_bad_aw
      $error("table_fsm: address wider than 12 bits");
   end

   logic [AW-1:0]     addr;
   logic [WORD_W-1:0] word;

   tfsm_addr #(.STATE_W(STATE_W), .IN_W(IN_W)) u_addr (
      .state   (state),
      .in_bits (in_bits),
      .addr    (addr)
   );

   tfsm_rom #(.STATE_W(STATE_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_rom (
      .clk  (clk),
      .rst  (rst),
      .addr (addr),
      .q    (word)
   );

   tfsm_unpack #(.STATE_W(STATE_W), .OUT_W(OUT_W)) u_unpack (
      .word     (word),
      .state    (state),
      .out_bits (out_bits)
   );
endmodule

// File: rtl/tfsm_checker.sv
module tfsm_checker #(
   parameter int STATE_W = 5,
   parameter int IN_W    = 2,
   parameter int OUT_W   = 2
) (
   input logic               clk,
   input logic               rst,
   input logic [IN_W-1:0]    in_bits,
   input logic [OUT_W-1:0]   out_bits,
   input logic [STATE_W-1:0] state
);
   localparam int ST_MASK  = (1 << STATE_W) - 1;
   localparam int OUT_MASK = (1 << OUT_W) - 1;

   assert_reset_R3: assert property (@(posedge clk)
      rst |=> (state == '0) && (out_bits == '0));

   assert_step_R4: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> int'(state) ==
         (tfsm_pkg::tfsm_next(int'($past(state)), int'($past(in_bits))) & ST_MASK));

   assert_moore_R5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> int'(out_bits) == (tfsm_pkg::tfsm_outs(int'(state)) & OUT_MASK));

   assert_recover_R7: assert property (@(posedge clk) disable iff (rst)
      !tfsm_pkg::tfsm_used(int'(state)) |=> (state == '0) && (out_bits == '0));
endmodule

bind table_fsm tfsm_checker #(.STATE_W(STATE_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_bits  (in_bits),
   .out_bits (out_bits),
   .state    (state)
);

// File: tb/table_fsm_bench.sv
`timescale 1ns/1ps
module table_fsm_bench;
   localparam int SW = 5;
   localparam int IW = 2;
   localparam int OW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [IW-1:0] in_bits = '0;
   logic [OW-1:0] out_bits;
   logic [SW-1:0] state;

   logic             prst = 1'b1;
   logic [SW+IW-1:0] paddr = '0;
   logic [SW+OW-1:0] pq;

   int n_run  = 0;
   int n_fail = 0;
   int ms     = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   table_fsm #(.STATE_W(SW), .IN_W(IW), .OUT_W(OW)) u_table_fsm (
      .clk(clk), .rst(rst), .in_bits(in_bits), .out_bits(out_bits), .state(state)
   );

   tfsm_rom #(.STATE_W(SW), .IN_W(IW), .OUT_W(OW)) u_probe (
      .clk(clk), .rst(prst), .addr(paddr), .q(pq)
   );

   // Independent reference of the demonstration table.
   function automatic int ref_next(input int s, input int i);
      bit a;
      bit b;
      a = i[0];
      b = i[1];
      if (s == 0) return a ? 1 : 0;
      if (s == 1) return b ? 2 : 3;
      if (s == 2) return 3;
      if (s == 3) return a ? 0 : 4;
      if (s == 4) return (a && b) ? 0 : 4;
      return 0;
   endfunction

   function automatic int ref_outs(input int s);
      if (s == 1) return 1;
      if (s == 2) return 2;
      if (s == 3) return 3;
      return 0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, compare at the next falling edge.
   task automatic cyc(input bit r, input int i, input string req);
      rst     = r;
      in_bits = IW'(i);
      @(posedge clk);
      ms = r ? 0 : ref_next(ms, i);
      @(negedge clk);
      chk({req, " state"}, int'(state), ms);
      chk({req, " outputs"}, int'(out_bits), ref_outs(ms));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr;
      @(negedge clk);
      @(negedge clk);
      // R3: state and outputs after reset
      chk("R3 reset state", int'(state), 0);
      chk("R3 reset outputs", int'(out_bits), 0);

      // R1 R2 R6 R7: sweep the whole table through a separate instance
      prst = 1'b0;
      for (int a = 0; a < (1 << (SW + IW)); a++) begin
         int s;
         int i;
         int nx;
         s = a % (1 << SW);
         i = a / (1 << SW);
         nx = ref_next(s, i);
         paddr = (SW + IW)'(a);
         @(posedge clk);
         @(negedge clk);
         chk("R1 R2 word next field", int'(pq[SW-1:0]), nx);
         chk("R2 R6 word output field", int'(pq[SW+OW-1:SW]), ref_outs(nx));
         if (s > 4) chk("R7 unused code recovers", int'(pq), 0);
      end

      // Directed paths through every branch
      cyc(1'b1, 0, "R3");
      cyc(1'b0, 0, "R8 hold in 0");
      cyc(1'b0, 2, "R8 input 1 ignored in 0");
      cyc(1'b0, 1, "R8 to 1");
      cyc(1'b0, 2, "R9 to 2");
      cyc(1'b0, 0, "R10 to 3");
      cyc(1'b0, 1, "R11 3 to 0");
      cyc(1'b0, 1, "R4 to 1");
      cyc(1'b0, 0, "R9 to 3");
      cyc(1'b0, 0, "R11 3 to 4");
      cyc(1'b0, 1, "R11 4 holds");
      cyc(1'b0, 2, "R11 4 holds");
      cyc(1'b0, 3, "R11 4 to 0");
      // R10: state 2 with every input value
      for (int v = 0; v < 4; v++) begin
         cyc(1'b0, 1, "R10 reach 1");
         cyc(1'b0, 2, "R10 reach 2");
         cyc(1'b0, v, "R10 2 to 3");
         cyc(1'b0, 1, "R11 back to 0");
      end
      // R3: reset wins over a pending branch (state 3, input would go to 4)
      cyc(1'b0, 1, "R4");
      cyc(1'b0, 0, "R9");
      cyc(1'b1, 0, "R3 reset overrides table");

      // R4 R5: pseudo-random input stream
      lfsr = 8'hA5;
      for (int n = 0; n < 400; n++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         cyc(1'b0, int'(lfsr[1:0]), "R4 R5 stream");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule